// File: doc/BRIEF.md
# Multi-lane DDR SPI Master Engine

This block is the transfer engine of an SPI master. It moves one byte per transfer across one, two or four data lanes and can run in double-data-rate fashion, so that data moves on both edges of the serial clock. The serial clock comes from the system clock through a programmable half-period divider. Its idle level (CPOL) and its transfer format (CPHA) are selectable, which gives four clocking modes. When quad lanes and DDR are used together, a whole byte crosses the bus in one serial clock period.

Software loads a byte into the single transmit buffer while the engine is idle, selects a lane mode and clock format, and pulses `start`. The engine then takes a snapshot of the eight-bit slave-select pattern and of the transfer configuration. It drives the active-low selects for the whole byte and shifts the data MSB first. At the end it moves the received byte into a read register, so the shifter is free for the next byte.

The engine keeps three sticky event flags: transfer done, write collision and mode fault. Each flag is cleared by writing a one to its bit, and each can raise the interrupt when its enable bit is set. A mode fault is raised when another master pulls the slave-select input low. It aborts the current transfer and releases the clock and data output enables.

Top module: `qspi_ddr_master`

## Requirements
- R1: With `lane_mode`=0 (single lane), the engine is full duplex and sends 8 steps MSB first. It drives bit 7 first on `io_out[0]`, with `io_oe`=4'b0001 while busy, and assembles the received byte from `io_in[1]`, the first sampled bit becoming bit 7.
- R2: With `lane_mode`=1 (dual), each step carries two bits, 4 steps per byte, on lanes 1:0. The pair [7:6] goes first, and the higher bit of each pair is on lane 1, both when sending and when receiving.
- R3: With `lane_mode`=2 or 3 (quad), each step carries a nibble, 2 steps per byte, on lanes 3:0. Nibble [7:4] goes first, with bit 7 on lane 3. In dual and quad modes all lanes point one way: `lanes_rx`=1 gives `io_oe`=0, and `lanes_rx`=0 drives every used lane.
- R4: A transfer produces 2 × steps SCK edges without DDR and one edge per step with DDR. Quad with DDR therefore completes the byte in exactly two edges (one SCK period).
- R5: SCK rests at `cpol` when idle and ends every transfer at that level. With `cpha`=0 the first step is on the lanes before the first edge. With `cpha`=1 it is launched on the leading edge. Data sent and received is correct in all four clock modes, with and without DDR.
- R6: Each SCK half period lasts `clk_div`+1 system clocks, so `clk_div`=0 gives half the system clock rate. `busy` stays high for (edges + 1 + (DDR and CPHA=1 ? 1 : 0)) × (`clk_div`+1) clocks, counted from the cycle after `start` is accepted.
- R7: While busy, `ss_n_o` equals the bitwise inverse of the `ss_sel` value captured at start, and changes to `ss_sel` during the transfer have no effect. When idle, `ss_n_o` is all ones.
- R8: A `tx_wr` pulse while busy sets the write-collision flag (`flags[1]`) and leaves the byte being sent unchanged. A `tx_wr` pulse while idle does not set the flag.
- R9: `ss_in_n` low sets the mode-fault flag (`flags[2]`), ends any transfer at once without setting the done flag, releases the selects, and forces `sck_oe` and `io_oe` to zero until the flag is cleared. A `start` pulse is ignored while the flag is set.
- R10: `rx_data` changes only when a transfer completes. During a transfer it keeps the previously received byte.
- R11: `flags[0]` (done) is set when a transfer completes. Each flag stays set until a one is written to its bit of `flag_clr`, and `irq` is high whenever any flag is set together with its bit of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr | input | 1 | Load strobe for the transmit byte |
| tx_data | input | 8 | Byte to send |
| start | input | 1 | Begins a transfer when idle |
| lane_mode | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| ddr_en | input | 1 | Move data on both SCK edges |
| lanes_rx | input | 1 | Dual/quad direction: 1 receive, 0 send |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Transfer format select |
| clk_div | input | DIV_W | SCK half period minus one, in system clocks |
| ss_sel | input | 8 | Slave-select pattern, one bit per slave |
| ss_in_n | input | 1 | Slave-select input, low means another master |
| flag_clr | input | 3 | Write-one-to-clear for done, collision, fault |
| irq_en | input | 3 | Interrupt enables per flag |
| io_in | input | 4 | Serial lane inputs |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| io_out | output | 4 | Serial lane outputs |
| io_oe | output | 4 | Per-lane output enables |
| ss_n_o | output | 8 | Active-low slave selects |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| flags | output | 3 | Sticky flags: [0] done, [1] collision, [2] fault |
| irq | output | 1 | Interrupt request |

## Verification
The in-line properties check on every cycle the following:
- the slave selects hold steady through a byte;
- SCK is back at its captured idle level when the byte ends;
- the number of launch and sample steps matches the lane mode;
- a load during a transfer raises the collision flag;
- a mode fault always finds the engine idle;
- flags never clear on their own.

Only the bench's scenarios can show that the right bits land on the right lanes in the right order. It does this by running a slave model that follows each clock mode and checks both directions of the exchange. The same scenarios show the exact transfer length for each divider, and that the select pattern ignores late changes of `ss_sel`.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  localparam int BYTE_W = 8;
  localparam int TICK_W = 5;   // holds up to 2*8+2 half periods
  localparam int NFLAG  = 3;

  typedef enum logic [1:0] {
    LN_SINGLE = 2'd0,
    LN_DUAL   = 2'd1,
    LN_QUAD   = 2'd2,
    LN_QUAD_B = 2'd3
  } lane_e;

  typedef struct packed {
    lane_e lanes;
    logic  ddr;
    logic  cpha;
    logic  cpol;
    logic  rx_dir;
  } xfer_cfg_t;

  function automatic int lane_bits(lane_e m);
    case (m)
      LN_SINGLE: return 1;
      LN_DUAL:   return 2;
      default:   return 4;
    endcase
  endfunction

  function automatic int step_count(lane_e m);
    return BYTE_W / lane_bits(m);
  endfunction

  // number of SCK edges in one byte
  function automatic int edge_count(xfer_cfg_t c);
    return c.ddr ? step_count(c.lanes) : 2 * step_count(c.lanes);
  endfunction

  // half-period index at which the byte is closed
  function automatic int final_tick(xfer_cfg_t c);
    return edge_count(c) + 1 + ((c.ddr && c.cpha) ? 1 : 0);
  endfunction

  // does half-period k (1-based) launch the next output step
  function automatic logic launch_at(xfer_cfg_t c, int k);
    int n;
    n = edge_count(c);
    if (k < 1 || k > n) return 1'b0;
    if (!c.ddr) return c.cpha ? (k % 2 == 1) : ((k % 2 == 0) && (k < n));
    return c.cpha ? 1'b1 : (k < n);
  endfunction

  // does half-period k (1-based) sample the input lanes
  function automatic logic sample_at(xfer_cfg_t c, int k);
    int n;
    n = edge_count(c);
    if (!c.ddr) return (k >= 1) && (k <= n) && (c.cpha ? (k % 2 == 0) : (k % 2 == 1));
    return c.cpha ? ((k >= 2) && (k <= n + 1)) : ((k >= 1) && (k <= n));
  endfunction

  function automatic logic [3:0] drive_mask(xfer_cfg_t c);
    if (c.lanes == LN_SINGLE) return 4'b0001;
    if (c.rx_dir) return 4'b0000;
    return (c.lanes == LN_DUAL) ? 4'b0011 : 4'b1111;
  endfunction

endpackage

// File: rtl/qspi_baud.sv
module qspi_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/qspi_lane_shifter.sv
module qspi_lane_shifter
  import qspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lane_e             lanes,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              launch,
  input  logic              sample,
  input  logic              finish,
  input  logic [3:0]        lanes_in,
  output logic [3:0]        lanes_out,
  output logic [BYTE_W-1:0] rx_byte
);

  logic [BYTE_W-1:0] tx_sr, rx_sr, rx_q, rx_next;
  logic [3:0]        pin_q;

  function automatic logic [3:0] head_slice(logic [BYTE_W-1:0] sr, lane_e m);
    case (lane_bits(m))
      1:       return {3'b000, sr[7]};
      2:       return {2'b00, sr[7:6]};
      default: return sr[7:4];
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] gather(logic [BYTE_W-1:0] sr, logic [3:0] din, lane_e m);
    case (lane_bits(m))
      1:       return {sr[6:0], din[1]};
      2:       return {sr[5:0], din[1:0]};
      default: return {sr[3:0], din[3:0]};
    endcase
  endfunction

  assign rx_next   = sample ? gather(rx_sr, lanes_in, lanes) : rx_sr;
  assign lanes_out = pin_q;
  assign rx_byte   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      pin_q <= '0;
    end else if (load) begin
      tx_sr <= load_data;
    end else if (launch) begin
      pin_q <= head_slice(tx_sr, lanes);
      tx_sr <= tx_sr << lane_bits(lanes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
      rx_q  <= '0;
    end else begin
      rx_sr <= rx_next;
      if (finish) rx_q <= rx_next;
    end
  end

endmodule

// File: rtl/qspi_sticky_flags.sv
module qspi_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q[i] <= 1'b0;
      else if (set[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] && !clr[i] |=> flag_q[i]);
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & en);

endmodule

// File: rtl/qspi_ddr_master.sv
module qspi_ddr_master
  import qspi_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SEL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              start,
  input  logic [1:0]        lane_mode,
  input  logic              ddr_en,
  input  logic              lanes_rx,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [SEL_W-1:0]  ss_sel,
  input  logic              ss_in_n,
  input  logic [NFLAG-1:0]  flag_clr,
  input  logic [NFLAG-1:0]  irq_en,
  input  logic [3:0]        io_in,
  output logic              sck_o,
  output logic              sck_oe,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic [SEL_W-1:0]  ss_n_o,
  output logic [BYTE_W-1:0] rx_data,
  output logic              busy,
  output logic [NFLAG-1:0]  flags,
  output logic              irq
);

  localparam int F_DONE = 0;
  localparam int F_WCOL = 1;
  localparam int F_MODF = 2;

  xfer_cfg_t        cfg_in, cfg_q;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic [TICK_W-1:0] k_q, k_next;
  logic             busy_q, sck_q;
  logic             tick;

  // named internal events
  logic go, prime, edge_now, launch_now, sample_now, end_now;
  logic wcol_evt, modf_evt, finish;
  logic modf_flag;
  logic [NFLAG-1:0] flag_set;
  lane_e lanes_sel;

  assign cfg_in = '{lanes: lane_e'(lane_mode), ddr: ddr_en, cpha: cpha,
                    cpol: cpol, rx_dir: lanes_rx};

  assign modf_evt   = !ss_in_n;
  assign go         = start && !busy_q && !modf_flag && ss_in_n;
  assign prime      = go && !cpha;
  assign k_next     = k_q + 1'b1;
  assign edge_now   = tick && (int'(k_next) <= edge_count(cfg_q));
  assign launch_now = tick && launch_at(cfg_q, int'(k_next));
  assign sample_now = tick && sample_at(cfg_q, int'(k_next));
  assign end_now    = tick && (int'(k_next) == final_tick(cfg_q));
  assign finish     = end_now && !modf_evt;
  assign wcol_evt   = tx_wr && busy_q;
  assign lanes_sel  = go ? cfg_in.lanes : cfg_q.lanes;

  qspi_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .half_div (div_q),
    .tick     (tick)
  );

  qspi_lane_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .lanes     (lanes_sel),
    .load      (tx_wr && !busy_q),
    .load_data (tx_data),
    .launch    (prime || launch_now),
    .sample    (sample_now),
    .finish    (finish),
    .lanes_in  (io_in),
    .lanes_out (io_out),
    .rx_byte   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      k_q    <= '0;
      cfg_q  <= '{lanes: LN_SINGLE, ddr: 1'b0, cpha: 1'b0, cpol: 1'b0, rx_dir: 1'b0};
      div_q  <= '0;
      sel_q  <= '0;
    end else if (modf_evt) begin
      busy_q <= 1'b0;
    end else if (go) begin
      busy_q <= 1'b1;
      sck_q  <= cpol;
      k_q    <= '0;
      cfg_q  <= cfg_in;
      div_q  <= clk_div;
      sel_q  <= ss_sel;
    end else if (busy_q && tick) begin
      k_q <= k_next;
      if (edge_now) sck_q  <= ~sck_q;
      if (end_now)  busy_q <= 1'b0;
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_DONE] = finish;
    flag_set[F_WCOL] = wcol_evt;
    flag_set[F_MODF] = modf_evt;
  end

  qspi_sticky_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .en    (irq_en),
    .flags (flags),
    .irq   (irq)
  );

  assign modf_flag = flags[F_MODF];
  assign busy      = busy_q;
  assign sck_o     = busy_q ? sck_q : cpol;
  assign sck_oe    = !modf_flag;
  assign io_oe     = (busy_q && !modf_flag) ? drive_mask(cfg_q) : 4'b0000;
  assign ss_n_o    = busy_q ? ~sel_q : {SEL_W{1'b1}};

  // ---------------- checker logic ----------------
  logic [4:0] launch_cnt, sample_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch_cnt <= '0;
      sample_cnt <= '0;
    end else if (go) begin
      launch_cnt <= {4'b0000, prime};
      sample_cnt <= '0;
    end else begin
      if (launch_now) launch_cnt <= launch_cnt + 1'b1;
      if (sample_now) sample_cnt <= sample_cnt + 1'b1;
    end
  end

  // R7
  ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(ss_n_o));

  // R5
  sck_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |-> sck_q == cfg_q.cpol);

  // R4
  step_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |-> int'(launch_cnt) == step_count(cfg_q.lanes));

  // R4
  step_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_now |-> int'(sample_cnt) + (sample_now ? 1 : 0) == step_count(cfg_q.lanes));

  // R8
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && busy_q |=> flags[F_WCOL]);

  // R9
  modf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_flag) |-> !busy_q);

endmodule

// File: tb/qspi_ddr_master_test.sv
module qspi_ddr_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic start = 1'b0;
  logic [1:0] lane_mode = '0;
  logic ddr_en = 1'b0, lanes_rx = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic [7:0] ss_sel = '0;
  logic ss_in_n = 1'b1;
  logic [2:0] flag_clr = '0, irq_en = '0;
  logic [3:0] io_in = '0;
  logic sck_o, sck_oe, busy, irq;
  logic [3:0] io_out, io_oe;
  logic [7:0] ss_n_o, rx_data;
  logic [2:0] flags;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_ddr_master #(.DIV_W(DIV_W), .SEL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data), .start(start),
    .lane_mode(lane_mode), .ddr_en(ddr_en), .lanes_rx(lanes_rx), .cpol(cpol),
    .cpha(cpha), .clk_div(clk_div), .ss_sel(ss_sel), .ss_in_n(ss_in_n),
    .flag_clr(flag_clr), .irq_en(irq_en), .io_in(io_in), .sck_o(sck_o),
    .sck_oe(sck_oe), .io_out(io_out), .io_oe(io_oe), .ss_n_o(ss_n_o),
    .rx_data(rx_data), .busy(busy), .flags(flags), .irq(irq));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model (samples at negedge) ----------------
  logic [7:0] s_byte = '0, sdr = '0, cap = '0, cap_byte = '0;
  logic [7:0] exp_sel = '0, prev_rx = '0;
  logic [3:0] prev_out = '0, oe_or = '0;
  logic prev_sck = 1'b0, prev_ss_low = 1'b0, sck_at_start = 1'b0;
  bit ss_bad = 0, rx_bad = 0;
  int e = 0, busy_cnt = 0;

  function automatic int bits_of(logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic int edges_of(logic [1:0] m, logic d);
    return d ? 8 / bits_of(m) : 16 / bits_of(m);
  endfunction

  function automatic bit slave_launches(int k);
    int n;
    n = edges_of(lane_mode, ddr_en);
    if (!ddr_en) return cpha ? (k % 2 == 1) : ((k % 2 == 0) && k < n);
    return cpha ? 1 : (k < n);
  endfunction

  function automatic bit slave_samples(int k);
    if (!ddr_en) return cpha ? (k % 2 == 0) : (k % 2 == 1);
    return cpha ? (k >= 2) : 1;
  endfunction

  task automatic slave_launch();
    case (bits_of(lane_mode))
      1: io_in = {2'b00, sdr[7], 1'b0};
      2: io_in = {2'b00, sdr[7:6]};
      default: io_in = sdr[7:4];
    endcase
    sdr = sdr << bits_of(lane_mode);
  endtask

  task automatic slave_capture(input logic [3:0] v);
    case (bits_of(lane_mode))
      1: cap = {cap[6:0], v[0]};
      2: cap = {cap[5:0], v[1:0]};
      default: cap = {cap[3:0], v[3:0]};
    endcase
  endtask

  always @(negedge clk) begin
    bit ss_low;
    ss_low = (ss_n_o != 8'hFF);
    if (ss_low && !prev_ss_low) begin
      e = 0; sdr = s_byte; cap = '0; sck_at_start = sck_o;
      if (!cpha) slave_launch();
    end else if (ss_low) begin
      if (sck_o != prev_sck) begin
        e++;
        if (slave_samples(e)) slave_capture(prev_out);
        if (slave_launches(e)) slave_launch();
      end
    end else if (prev_ss_low) begin
      if (ddr_en && cpha) slave_capture(prev_out);
      cap_byte = cap;
    end
    if (busy) begin
      busy_cnt++;
      oe_or |= io_oe;
      if (ss_n_o != ~exp_sel) ss_bad = 1;
      if (rx_data != prev_rx) rx_bad = 1;
    end
    prev_sck = sck_o; prev_out = io_out; prev_ss_low = ss_low;
  end

  task automatic clear_flags();
    @(posedge clk); #1 flag_clr = 3'b111;
    @(posedge clk); #1 flag_clr = 3'b000;
  endtask

  task automatic run_xfer(input logic [1:0] m, input logic d, input logic ph, input logic po,
                          input logic rxd, input int dv, input logic [7:0] txb,
                          input logic [7:0] sb, input logic [7:0] sel, input bit inject_wcol);
    int exp_e, exp_dur, guard;
    logic [3:0] exp_oe;
    @(posedge clk); #1;
    lane_mode = m; ddr_en = d; cpha = ph; cpol = po; lanes_rx = rxd;
    clk_div = DIV_W'(dv); ss_sel = sel; exp_sel = sel; s_byte = sb;
    tx_data = txb; tx_wr = 1'b1;
    @(posedge clk); #1;
    tx_wr = 1'b0; start = 1'b1;
    busy_cnt = 0; oe_or = '0; ss_bad = 0; rx_bad = 0;
    @(posedge clk); #1;
    start = 1'b0; ss_sel = ~sel;  // late change must be ignored
    if (inject_wcol) begin
      @(posedge clk); #1 tx_wr = 1'b1; tx_data = ~txb;
      @(posedge clk); #1 tx_wr = 1'b0;
    end
    guard = 0;
    do begin @(negedge clk); guard++; end while (busy && guard < 2000);
    @(negedge clk);
    exp_e   = edges_of(m, d);
    exp_dur = (exp_e + 1 + ((d && ph) ? 1 : 0)) * (dv + 1);
    exp_oe  = (m == 2'd0) ? 4'b0001 : rxd ? 4'b0000 : (m == 2'd1) ? 4'b0011 : 4'b1111;
    // R1 R2 R3: received byte
    check(rx_data == sb, $sformatf("R1/R2/R3 rx m=%0d d=%0d ph=%0d", m, d, ph), rx_data, sb);
    // R1 R2 R3: byte seen by slave
    if (!(m != 2'd0 && rxd))
      check(cap_byte == txb, $sformatf("R2/R3 tx m=%0d d=%0d ph=%0d", m, d, ph), cap_byte, txb);
    check(oe_or == exp_oe, "R3 lane enables", oe_or, exp_oe);
    check(e == exp_e, $sformatf("R4 edges m=%0d d=%0d", m, d), e, exp_e);
    check(busy_cnt == exp_dur, $sformatf("R6 duration div=%0d", dv), busy_cnt, exp_dur);
    check(sck_o == po && sck_at_start == po, "R5 sck idle level", {sck_at_start, sck_o}, {po, po});
    check(!ss_bad && ss_n_o == 8'hFF, "R7 slave select", {ss_bad, ss_n_o}, {1'b0, 8'hFF});
    check(!rx_bad, "R10 rx held during transfer", rx_bad, 0);
    check(flags[1] == inject_wcol, "R8 collision flag", flags[1], inject_wcol);
    check(flags[0] == 1'b1 && irq == 1'b1, "R11 done flag and irq", {flags[0], irq}, 2'b11);
    prev_rx = sb;
    clear_flags();
    @(negedge clk);
    check(flags == 3'b000 && irq == 1'b0, "R11 write-one-to-clear", {flags, irq}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int n;
    cpol = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flags == 3'b000 && irq == 1'b0 && busy == 1'b0, "R11 reset flags", {flags, irq, busy}, 0);
    check(ss_n_o == 8'hFF, "R7 reset selects", ss_n_o, 8'hFF);
    check(sck_o == 1'b1 && sck_oe == 1'b1 && io_oe == 4'b0, "R5 reset sck", {sck_o, sck_oe, io_oe}, 6'b110000);
    #1 rst_n = 1'b1;
    irq_en = 3'b001;
    n = 0;
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int ph = 0; ph < 2; ph++)
          for (int po = 0; po < 2; po++)
            for (int dv = 0; dv < 3; dv++) begin
              run_xfer(2'(m), d[0], ph[0], po[0], n[0], dv, 8'(8'h5A ^ (n * 37)),
                       8'(8'hC3 + n * 23), 8'(1 << (n % 8)), 1'b0);
              n++;
            end

    // R8: write during transfer
    irq_en = 3'b010;
    run_xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 8'hA5, 8'h3C, 8'h10, 1'b1);

    // R9: mode fault
    irq_en = 3'b100;
    @(posedge clk); #1;
    lane_mode = 2'd0; ddr_en = 0; cpha = 0; cpol = 0; clk_div = DIV_W'(3);
    ss_sel = 8'h04; exp_sel = 8'h04; tx_data = 8'h96; tx_wr = 1'b1;
    @(posedge clk); #1 tx_wr = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (6) @(posedge clk);
    #1 ss_in_n = 1'b0;
    @(posedge clk); #1 ss_in_n = 1'b1;
    @(negedge clk);
    check(flags[2] == 1'b1 && irq == 1'b1, "R9 fault flag", {flags[2], irq}, 2'b11);
    check(busy == 1'b0 && ss_n_o == 8'hFF, "R9 abort", {busy, ss_n_o}, 9'h0FF);
    check(sck_oe == 1'b0 && io_oe == 4'b0, "R9 enables dropped", {sck_oe, io_oe}, 0);
    check(flags[0] == 1'b0, "R9 no done on abort", flags[0], 0);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R9 start ignored", busy, 0);
    clear_flags();
    @(negedge clk);
    check(sck_oe == 1'b1 && flags == 3'b000, "R9 recovery", {sck_oe, flags}, 4'b1000);
    prev_rx = rx_data;
    irq_en = 3'b001;
    run_xfer(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 8'h81, 8'h7E, 8'h80, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule